// File: doc/BRIEF.md
# Converter Result FIFO

This block sits behind an analog-to-digital converter front end and holds its finished results in a short first-in first-out queue until a DMA engine or software collects them. A result strobe brings a 12-bit sample and a conversion error flag. Each accepted sample is formatted into a 16-bit queue entry. It can be narrowed to its eight most significant bits, and the error flag can be tagged onto it. A pop port removes the oldest entry.

Software sees one 32-bit control and status word. It can write four control bits and a 4-bit threshold, and read back the empty and full state, the number of held results, and two sticky flags for overflow and underflow. Writing one to a sticky flag clears it. An interrupt line and a DMA request line follow a comparison between the held count and the threshold. The DMA request is additionally gated by a control bit.

Top module: `conv_result_fifo`

## Requirements
- R1: After reset the control word reads 32'h0000_0100: all control bits, the threshold, both sticky flags and the count read zero, and the empty flag (bit 8) reads one.
- R2: A sample on the result strobe is pushed only while control bit 0 (store) is one. While it is zero, samples change neither the count nor the queue.
- R3: An entry holds the sample in bits 11:0 with bits 14:12 zero. While control bit 1 (narrow) is one, bits 7:0 hold sample bits 11:4 and bits 14:8 are zero.
- R4: While control bit 2 (tag) is one, entry bit 15 carries the sample's error flag. Otherwise bit 15 is zero.
- R5: The queue holds 4 entries and pops them in push order. A pop in cycle N places the oldest entry on pop_data after that clock edge. pop_data holds its value until the next pop.
- R6: A push that arrives while the queue is full and no pop occurs in the same cycle is dropped, and the stored entries stay unchanged. It also sets the sticky overflow flag in bit 11.
- R7: A pop on an empty queue puts zero on pop_data and leaves the count unchanged. It also sets the sticky underflow flag in bit 10.
- R8: Writing one to bit 10 or bit 11 clears that flag, and writing zero leaves it unchanged. If a new event occurs in the same cycle as a clear, the flag is set.
- R9: Bits 19:16 read the number of held entries, bit 8 reads one when that number is zero, and bit 9 reads one when it is 4. Bits 7:4, 15:12, 23:20 and 31:28 read zero.
- R10: Bits 27:24 hold a threshold. irq is one whenever count >= threshold. dma_req equals irq ANDed with control bit 3.
- R11: A push and a pop in the same cycle are both accepted whenever the queue is not empty. A queue that is neither empty nor full keeps its count.
- R12: A register write updates bits 3:0 and 27:24 from the written word. The new values are visible on reg_rdata after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Result strobe, one cycle per finished conversion |
| smp_data | input | 12 | Conversion result |
| smp_err | input | 1 | Conversion error flag |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Value written to the control word |
| reg_rdata | output | 32 | Current control and status word |
| pop | input | 1 | Remove the oldest entry |
| pop_data | output | 16 | Entry taken by the last pop |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a full queue that receives a push and a pop in the same cycle, with a sticky flag being cleared at the moment a new overflow or underflow event sets it again. Directed sequences fill the queue to four entries, push and pop on exact edges, and write clear masks both alongside and apart from those events. After that, a long seeded random phase keeps the push rate close to the pop rate and issues occasional register writes. This holds the count near its bounds, so the rare coincidences occur many times, and a cycle-accurate bench model checks every one of them.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
   // Bit positions inside the control and status word (software decodes these)
   localparam int unsigned B_STORE  = 0;
   localparam int unsigned B_NARROW = 1;
   localparam int unsigned B_TAG    = 2;
   localparam int unsigned B_REQEN  = 3;
   localparam int unsigned B_EMPTY  = 8;
   localparam int unsigned B_FULL   = 9;
   localparam int unsigned B_UNF    = 10;
   localparam int unsigned B_OVF    = 11;
   localparam int unsigned F_LVL_LO = 16;
   localparam int unsigned F_THR_LO = 24;
   localparam int unsigned FIELD_W  = 4;
   localparam int unsigned WORD_W   = 32;

   typedef struct packed {
      logic req_en;
      logic tag;
      logic narrow;
      logic store;
   } ctl_t;
endpackage

// File: rtl/cfifo_pack.sv
module cfifo_pack #(
   parameter int unsigned SMP_W   = 12,
   parameter int unsigned ENTRY_W = 16,
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned ERR_POS = 15
) (
   input  logic [SMP_W-1:0]   smp,
   input  logic               err,
   input  logic               narrow,
   input  logic               tag,
   output logic [ENTRY_W-1:0] entry
);
   logic [ENTRY_W-1:0] wide_val;
   logic [ENTRY_W-1:0] narrow_val;

   if (ENTRY_W <= SMP_W) begin : g_chk_w
      $error("cfifo_pack: ENTRY_W must exceed SMP_W");
   end
   if (ERR_POS >= ENTRY_W || ERR_POS < SMP_W) begin : g_chk_e
      $error("cfifo_pack: ERR_POS must lie above the sample inside the entry");
   end

   assign wide_val = ENTRY_W'(smp);

   if (SMP_W > BYTE_W) begin : g_reduce
      // keep the most significant bits
      assign narrow_val = ENTRY_W'(smp[SMP_W-1 -: BYTE_W]);
   end else begin : g_pass
      assign narrow_val = ENTRY_W'(smp);
   end

   always_comb begin
      entry = narrow ? narrow_val : wide_val;
      if (tag) entry[ERR_POS] = err;
   end
endmodule

// File: rtl/cfifo_ring.sv
module cfifo_ring #(
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned ENTRY_W = 16,
   localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic               pop,
   output logic [ENTRY_W-1:0] rd_data,
   output logic [LVL_W-1:0]   level,
   output logic               empty,
   output logic               full,
   output logic               push_drop,
   output logic               pop_miss
);
   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [AW-1:0]      head, tail;
   logic               push_ok, pop_ok;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_d
      $error("cfifo_ring: DEPTH must be a power of two, at least 2");
   end

   assign empty     = (level == '0);
   assign full      = (level == LVL_W'(DEPTH));
   assign pop_ok    = pop && !empty;
   // a pop in the same cycle frees the slot the push needs
   assign push_ok   = push && (!full || pop);
   assign push_drop = push && !push_ok;
   assign pop_miss  = pop && empty;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                          mem[i] <= '0;
         else if (push_ok && tail == AW'(i))  mem[i] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head    <= '0;
         tail    <= '0;
         level   <= '0;
         rd_data <= '0;
      end else begin
         if (push_ok) tail <= tail + 1'b1;
         if (pop_ok)  head <= head + 1'b1;
         if (pop)     rd_data <= pop_ok ? mem[head] : '0;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH)) else $error("level beyond depth"); // R9
   AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pop && empty |=> rd_data == '0) else $error("empty pop data"); // R7
   AST_EMPTY_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      pop && empty && !push |=> empty) else $error("empty pop level"); // R7
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop |=> full) else $error("full push changed level"); // R6
   AST_BOTH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop && !empty && !full |=> $stable(level)) else $error("push+pop level"); // R11
endmodule

// File: rtl/cfifo_csr.sv
module cfifo_csr
   import cfifo_pkg::*;
#(
   parameter int unsigned LVL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [LVL_W-1:0]  level,
   input  logic              empty,
   input  logic              full,
   input  logic              ovf_evt,
   input  logic              unf_evt,
   output ctl_t              ctl,
   output logic [WORD_W-1:0] rdata,
   output logic              irq,
   output logic              dma_req
);
   logic [FIELD_W-1:0] thresh;
   logic               ovf, unf;
   logic [FIELD_W-1:0] lvl_field;
   logic               unused_wbits;

   if (LVL_W > FIELD_W) begin : g_chk_l
      $error("cfifo_csr: level does not fit its field");
   end

   assign lvl_field    = FIELD_W'(level);
   assign unused_wbits = ^{wdata[WORD_W-1:F_THR_LO+FIELD_W], wdata[F_THR_LO-1:B_OVF+1],
                           wdata[B_UNF-1:B_REQEN+1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl    <= '0;
         thresh <= '0;
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else begin
         if (wr) begin
            ctl    <= ctl_t'(wdata[B_REQEN:B_STORE]);
            thresh <= wdata[F_THR_LO +: FIELD_W];
         end
         // a new event wins over a clear in the same cycle
         if (ovf_evt)                 ovf <= 1'b1;
         else if (wr && wdata[B_OVF]) ovf <= 1'b0;
         if (unf_evt)                 unf <= 1'b1;
         else if (wr && wdata[B_UNF]) unf <= 1'b0;
      end
   end

   always_comb begin
      rdata                       = '0;
      rdata[B_REQEN:B_STORE]      = ctl;
      rdata[B_EMPTY]              = empty;
      rdata[B_FULL]               = full;
      rdata[B_UNF]                = unf;
      rdata[B_OVF]                = ovf;
      rdata[F_LVL_LO +: FIELD_W]  = lvl_field;
      rdata[F_THR_LO +: FIELD_W]  = thresh;
   end

   assign irq     = ({1'b0, lvl_field} >= {1'b0, thresh});
   assign dma_req = irq && ctl.req_en;

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !(wr && wdata[B_OVF]) |=> ovf) else $error("overflow flag lost"); // R6
   AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      unf && !(wr && wdata[B_UNF]) |=> unf) else $error("underflow flag lost"); // R7
   AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      wr && wdata[B_OVF] && !ovf_evt |=> !ovf) else $error("overflow clear"); // R8
   AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> ctl.req_en) else $error("request while gated"); // R10
endmodule

// File: rtl/conv_result_fifo.sv
module conv_result_fifo
   import cfifo_pkg::*;
#(
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned SMP_W   = 12,
   parameter int unsigned ENTRY_W = 16,
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned ERR_POS = 15,
   localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [SMP_W-1:0]   smp_data,
   input  logic               smp_err,
   input  logic               reg_wr,
   input  logic [WORD_W-1:0]  reg_wdata,
   output logic [WORD_W-1:0]  reg_rdata,
   input  logic               pop,
   output logic [ENTRY_W-1:0] pop_data,
   output logic               dma_req,
   output logic               irq
);
   ctl_t               ctl;
   logic [ENTRY_W-1:0] entry;
   logic [LVL_W-1:0]   level;
   logic               empty, full, push_drop, pop_miss, push_req;

   assign push_req = smp_valid && ctl.store;

   cfifo_pack #(.SMP_W(SMP_W), .ENTRY_W(ENTRY_W), .BYTE_W(BYTE_W), .ERR_POS(ERR_POS)) u_pack (
      .smp(smp_data), .err(smp_err), .narrow(ctl.narrow), .tag(ctl.tag), .entry(entry));

   cfifo_ring #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_ring (
      .clk(clk), .rst_n(rst_n), .push(push_req), .wdata(entry), .pop(pop),
      .rd_data(pop_data), .level(level), .empty(empty), .full(full),
      .push_drop(push_drop), .pop_miss(pop_miss));

   cfifo_csr #(.LVL_W(LVL_W)) u_csr (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .level(level),
      .empty(empty), .full(full), .ovf_evt(push_drop), .unf_evt(pop_miss),
      .ctl(ctl), .rdata(reg_rdata), .irq(irq), .dma_req(dma_req));

   AST_STORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid && !reg_rdata[B_STORE] && !pop |=> $stable(level)) else $error("stored while off"); // R2
endmodule

// File: tb/conv_result_fifo_test.sv
`timescale 1ns/1ps
module conv_result_fifo_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0, smp_err = 1'b0, pop = 1'b0, reg_wr = 1'b0;
   logic [11:0] smp_data = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [15:0] pop_data;
   logic        dma_req, irq;

   int checks = 0, errors = 0, cycles = 0;

   // bench model
   logic [15:0] mq[$];
   logic [3:0]  m_ctl = '0, m_thr = '0;
   logic        m_ovf = 1'b0, m_unf = 1'b0;
   logic [15:0] m_pd = '0;

   always #2.5 clk = ~clk;

   conv_result_fifo uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_err(smp_err), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pop(pop), .pop_data(pop_data), .dma_req(dma_req), .irq(irq));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL R5 watchdog expired act=%0d exp<=150000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [15:0] fmt(input logic [11:0] d, input logic e);
      logic [15:0] r;
      r = m_ctl[1] ? {8'h00, d[11:4]} : {4'h0, d};  // R3
      if (m_ctl[2]) r[15] = e;                       // R4
      return r;
   endfunction

   function automatic logic [31:0] exp_rdata();
      logic [31:0] r = '0;
      r[3:0]   = m_ctl;
      r[8]     = (mq.size() == 0);
      r[9]     = (mq.size() == 4);
      r[10]    = m_unf;
      r[11]    = m_ovf;
      r[19:16] = 4'(mq.size());
      r[27:24] = m_thr;
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic cyc(input bit v, input logic [11:0] d, input bit e, input bit p,
                      input bit w, input logic [31:0] wd);
      bit push_req, pop_ok, push_ok, ovf_evt, unf_evt, lvl_ge;
      logic [15:0] ent;
      smp_valid = v; smp_data = d; smp_err = e; pop = p; reg_wr = w; reg_wdata = wd;
      @(posedge clk);
      push_req = v && m_ctl[0];
      ent      = fmt(d, e);
      pop_ok   = p && (mq.size() != 0);
      push_ok  = push_req && (mq.size() < 4 || p);
      ovf_evt  = push_req && !push_ok;
      unf_evt  = p && (mq.size() == 0);
      if (p) m_pd = pop_ok ? mq.pop_front() : 16'h0;
      if (push_ok) mq.push_back(ent);
      if (ovf_evt) m_ovf = 1'b1; else if (w && wd[11]) m_ovf = 1'b0;
      if (unf_evt) m_unf = 1'b1; else if (w && wd[10]) m_unf = 1'b0;
      if (w) begin m_ctl = wd[3:0]; m_thr = wd[27:24]; end  // R12
      #1;
      lvl_ge = (mq.size() >= int'(m_thr));
      chk("R9 status word", reg_rdata, exp_rdata());
      chk("R5 pop data", {16'h0, pop_data}, {16'h0, m_pd});
      chk("R10 irq", {31'h0, irq}, {31'h0, lvl_ge});
      chk("R10 dma_req", {31'h0, dma_req}, {31'h0, lvl_ge && m_ctl[3]});
      smp_valid = 0; pop = 0; reg_wr = 0;
   endtask

   task automatic push(input logic [11:0] d, input bit e); cyc(1, d, e, 0, 0, '0); endtask
   task automatic popc();                                cyc(0, '0, 0, 1, 0, '0); endtask
   task automatic wreg(input logic [31:0] wd);           cyc(0, '0, 0, 0, 1, wd); endtask

   initial begin
      void'($urandom(32'd4271));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 reset word", reg_rdata, 32'h0000_0100);
      chk("R1 reset pop_data", {16'h0, pop_data}, 32'h0);
      chk("R1 reset dma_req", {31'h0, dma_req}, 32'h0);

      // R2: store disabled
      push(12'h111, 0); push(12'h222, 1); push(12'h333, 0);
      chk("R2 level with store off", {28'h0, reg_rdata[19:16]}, 32'h0);

      // R3 / R4 formatting
      wreg(32'h1); push(12'hABC, 1); popc();
      chk("R3 wide entry untagged", {16'h0, pop_data}, 32'h0ABC);
      wreg(32'h5); push(12'h123, 1); popc();
      chk("R4 tagged error", {16'h0, pop_data}, 32'h8123);
      push(12'h456, 0); popc();
      chk("R4 tagged clean", {16'h0, pop_data}, 32'h0456);
      wreg(32'h3); push(12'hABC, 1); popc();
      chk("R3 narrow entry", {16'h0, pop_data}, 32'h00AB);

      // R6 overflow and R5 order
      wreg(32'h1);
      for (int i = 1; i <= 4; i++) push(12'hA00 + 12'(i), 0);
      chk("R9 full bit", {31'h0, reg_rdata[9]}, 32'h1);
      push(12'hA05, 0);
      chk("R6 overflow flag", {31'h0, reg_rdata[11]}, 32'h1);
      chk("R6 level after drop", {28'h0, reg_rdata[19:16]}, 32'h4);
      for (int i = 1; i <= 4; i++) begin
         popc();
         chk("R5 pop order", {16'h0, pop_data}, 32'h0A00 + 32'(i));
      end
      chk("R9 empty bit", {31'h0, reg_rdata[8]}, 32'h1);

      // R7 underflow
      popc();
      chk("R7 empty pop data", {16'h0, pop_data}, 32'h0);
      chk("R7 underflow flag", {31'h0, reg_rdata[10]}, 32'h1);
      chk("R7 level unchanged", {28'h0, reg_rdata[19:16]}, 32'h0);

      // R8 write one to clear
      wreg(32'h1);
      chk("R8 zero write keeps flags", {30'h0, reg_rdata[11:10]}, 32'h3);
      cyc(0, '0, 0, 1, 1, 32'h0000_0C01);
      chk("R8 event beats clear", {31'h0, reg_rdata[10]}, 32'h1);
      chk("R8 clear ovf", {31'h0, reg_rdata[11]}, 32'h0);
      wreg(32'h0000_0C01);
      chk("R8 clear unf", {31'h0, reg_rdata[10]}, 32'h0);

      // R10 threshold, R12 write
      wreg(32'h0200_0009);
      chk("R12 thresh field", {28'h0, reg_rdata[27:24]}, 32'h2);
      chk("R10 below threshold", {31'h0, irq}, 32'h0);
      push(12'h010, 0);
      chk("R10 still below", {31'h0, irq}, 32'h0);
      push(12'h020, 0);
      chk("R10 irq at threshold", {31'h0, irq}, 32'h1);
      chk("R10 dma at threshold", {31'h0, dma_req}, 32'h1);
      wreg(32'h0200_0001);
      chk("R10 dma gated", {31'h0, dma_req}, 32'h0);

      // R11 simultaneous push and pop
      cyc(1, 12'h030, 0, 1, 0, '0);
      chk("R11 level kept", {28'h0, reg_rdata[19:16]}, 32'h2);
      chk("R11 popped oldest", {16'h0, pop_data}, 32'h0010);
      push(12'h040, 0); push(12'h050, 0);
      cyc(1, 12'h060, 0, 1, 0, '0);
      chk("R11 full push+pop accepted", {28'h0, reg_rdata[19:16]}, 32'h4);
      chk("R11 no overflow", {31'h0, reg_rdata[11]}, 32'h0);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r = $urandom;
         logic [31:0] wd = $urandom;
         if (r[7:5] != 0) wd[0] = 1'b1;
         cyc(r[0], r[19:8], r[1], (r[3:2] == 0) || (r[3:2] == 1 && r[4]), r[31:28] == 0, wd);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule